// File: doc/BRIEF.md
# SDRAM Software-Stepped Command Issuer

This block is the command front end of an SDRAM controller. Software steps it through power-up. It programs a configuration word that holds the geometry, the bus width and the timing. It then picks an operation in an operation register and writes once into the memory window for each command it wants on the SDRAM pins. Each window access produces exactly one command of the chosen kind. The block holds the acknowledge back until that command's minimum delay has passed.

Once the operation register is set back to normal, two things follow. A programmable interval timer starts requesting auto-refresh cycles, and a window access becomes an activate/precharge placeholder; the data path is not part of this block. The block also reports the addressable capacity, derived from the configuration word.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After reset the command pins show deselect (cs_n=1, ras_n=1, cas_n=1, we_n=1), sd_cke is 0, win_ack is 0, all registers read 0, and size_bytes is 0x400000.
- R2: Register address 0 is the configuration word (32 bits), 1 the operation code (3 bits, upper bits read 0) and 2 the refresh interval (RT_W bits). A read returns the last value written, in the cycle after reg_addr is presented.
- R3: Configuration fields are col code [1:0] (columns-8), row code [3:2] (rows-11), bank code [4] (bank bits-1), wide16 [5], CAS [7:6], tWR [11:8], tRC [15:12], tRP [19:16], tRCD [23:20], tRAS [27:24], tXSR [31:28]. size_bytes is 2^(rows+cols+banks+1) when wide16 is 1 and 2^(rows+cols+banks+2) otherwise, one cycle after the write.
- R4: Operation 1 (NOP): each access drives cs_n/ras_n/cas_n/we_n = 0,1,1,1 and sets sd_cke, which then stays 1. The acknowledge follows tXSR cycles after the command if sd_cke was 0, and 1 cycle after otherwise.
- R5: Operation 2 (precharge all): each access drives 0,0,1,0 with address bit 10 high, and the acknowledge follows tRP cycles later.
- R6: Operation 3 (auto-refresh): each access drives one 0,0,0,1 command, so eight accesses give eight refreshes. The acknowledge follows tRC cycles later.
- R7: Operation 4 (load mode): the command is 0,0,0,0 with bank lines 0 and address = CAS<<4 | BURST_CODE. The acknowledge follows 2 cycles later.
- R8: Operation 0 (codes 5 to 7 act the same, normal): an access drives activate 0,0,1,1 (bank 0, row 0). After max(tRAS, tRCD+tWR) cycles it drives precharge-all, and the acknowledge follows tRP cycles after that.
- R9: In normal operation with interval P>0, refreshes occur every P cycles. Writing the interval restarts the timer and drops pending refreshes. The timer is frozen in other operations, and P=0 disables it.
- R10: A refresh pending when an access is requested in an idle cycle is issued before that access's first command.
- R11: Expirations during a busy period accumulate (up to 2^PEND_W-1) and each is issued later, none lost.
- R12: Every command lasts one cycle, with deselect between commands. win_ack is a one-cycle pulse, and a timing field of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered readback of the selected register |
| win_req | input | 1 | Memory-window access request, held until win_ack |
| win_ack | output | 1 | One-cycle access acknowledge |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address lines |
| size_bytes | output | SIZE_W | Addressable capacity in bytes |

## Verification
The bench keeps the default parameters (13 address lines, 2 bank lines, 16-bit interval, 2-bit pending count, burst code 0). It programs tRC=3, tRP=3 and tRAS=11, so a normal access lasts 14 cycles while a refresh occupies only 4. With that ratio, a refresh interval of 6 or 7 expires twice inside one access. The timer ends up with a backlog the bench can count, and an access arrives while a refresh is pending. An interval of 20 gives clean, isolated periodic refreshes whose spacing can be measured.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    OP_NORMAL = 3'd0,
    OP_NOP    = 3'd1,
    OP_PALL   = 3'd2,
    OP_AREF   = 3'd3,
    OP_LMR    = 3'd4
  } op_e;

  // configuration word, most significant field first
  typedef struct packed {
    logic [3:0] t_xsr;
    logic [3:0] t_ras;
    logic [3:0] t_rcd;
    logic [3:0] t_rp;
    logic [3:0] t_rc;
    logic [3:0] t_wr;
    logic [1:0] cas;
    logic       wide16;
    logic       bank_code;
    logic [1:0] row_code;
    logic [1:0] col_code;
  } cfg_t;

  localparam int REG_W = 32;
  localparam int TW    = 4;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_LMR   = 4'b0000;

  function automatic logic is_normal(input op_e m);
    return !(m inside {OP_NOP, OP_PALL, OP_AREF, OP_LMR});
  endfunction

endpackage

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int RT_W   = 16,
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output op_e               op_o,
  output logic [RT_W-1:0]   period_o,
  output logic              period_load_o,
  output logic [1:0]        cas_o,
  output logic [TW-1:0]     trp_o,
  output logic [TW-1:0]     trc_o,
  output logic [TW-1:0]     tras_o,
  output logic [TW-1:0]     trcd_o,
  output logic [TW-1:0]     twr_o,
  output logic [TW-1:0]     txsr_o,
  output logic [SIZE_W-1:0] size_o
);

  localparam int SHW = 6;

  cfg_t       cfg_q;
  logic [2:0] op_q;
  logic [SHW-1:0] shift;

  assign period_load_o = wr_i && (addr_i == 2'd2);
  assign op_o   = op_e'(op_q);
  assign cas_o  = cfg_q.cas;
  assign trp_o  = cfg_q.t_rp;
  assign trc_o  = cfg_q.t_rc;
  assign tras_o = cfg_q.t_ras;
  assign trcd_o = cfg_q.t_rcd;
  assign twr_o  = cfg_q.t_wr;
  assign txsr_o = cfg_q.t_xsr;

  // rows(code+11) + cols(code+8) + banks(code+1) + bytes per word
  assign shift = SHW'(cfg_q.col_code) + SHW'(cfg_q.row_code) + SHW'(cfg_q.bank_code)
               + SHW'(20) + (cfg_q.wide16 ? SHW'(1) : SHW'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      op_q     <= 3'd0;
      period_o <= '0;
      rdata_o  <= '0;
      size_o   <= SIZE_W'(1) << 22;
    end else begin
      if (wr_i) begin
        case (addr_i)
          2'd0:    cfg_q    <= cfg_t'(wdata_i);
          2'd1:    op_q     <= wdata_i[2:0];
          2'd2:    period_o <= wdata_i[RT_W-1:0];
          default: ;
        endcase
      end
      case (addr_i)
        2'd0:    rdata_o <= cfg_q;
        2'd1:    rdata_o <= REG_W'(op_q);
        2'd2:    rdata_o <= REG_W'(period_o);
        default: rdata_o <= '0;
      endcase
      size_o <= SIZE_W'(1) << shift;
    end
  end

endmodule

// File: rtl/sdcmd_rtimer.sv
module sdcmd_rtimer #(
  parameter int RT_W   = 16,
  parameter int PEND_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_i,
  input  logic [RT_W-1:0] period_i,
  input  logic            load_i,
  input  logic [RT_W-1:0] load_val_i,
  input  logic            take_i,
  output logic            pend_o
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [RT_W-1:0]   cnt;
  logic [PEND_W-1:0] pend;
  logic              active;
  logic              expire;

  assign active = run_i && (period_i != '0);
  assign expire = active && (cnt == '0);
  assign pend_o = (pend != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= '0;
    end else if (load_i) begin
      cnt  <= (load_val_i == '0) ? '0 : load_val_i - 1'b1;
      pend <= '0;
    end else begin
      if (active)
        cnt <= (cnt == '0) ? period_i - 1'b1 : cnt - 1'b1;
      if (expire && !take_i && pend != PEND_MAX)
        pend <= pend + 1'b1;
      else if (!expire && take_i)
        pend <= pend - 1'b1;
    end
  end

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int BURST_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op_i,
  input  logic              win_req_i,
  input  logic              ref_pend_i,
  input  logic [1:0]        cas_i,
  input  logic [TW-1:0]     trp_i,
  input  logic [TW-1:0]     trc_i,
  input  logic [TW-1:0]     tras_i,
  input  logic [TW-1:0]     trcd_i,
  input  logic [TW-1:0]     twr_i,
  input  logic [TW-1:0]     txsr_i,
  output logic              ref_take_o,
  output logic              win_ack_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int CW = TW + 1;
  localparam logic [ADDR_W-1:0] ADDR_A10 = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] MODE_WORD_BASE = ADDR_W'(3'(BURST_CODE));

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_WAIT} st_e;

  st_e            state;
  logic [CW-1:0]  cnt;
  logic           give_ack;
  logic [3:0]     cmd_q;
  logic [CW-1:0]  act_len;
  logic [CW-1:0]  rcd_wr;

  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  assign rcd_wr     = CW'(trcd_i) + CW'(twr_i);
  assign act_len    = (CW'(tras_i) > rcd_wr) ? CW'(tras_i) : rcd_wr;
  assign ref_take_o = (state == S_IDLE) && is_normal(op_i) && ref_pend_i;

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      give_ack  <= 1'b0;
      win_ack_o <= 1'b0;
      cke_o     <= 1'b0;
      cmd_q     <= CMD_DESEL;
      ba_o      <= '0;
      addr_o    <= '0;
    end else begin
      win_ack_o <= 1'b0;
      cmd_q     <= CMD_DESEL;
      ba_o      <= '0;
      addr_o    <= '0;
      case (state)
        S_IDLE: begin
          if (ref_take_o) begin
            cmd_q    <= CMD_REF;
            cnt      <= at_least_one(CW'(trc_i));
            give_ack <= 1'b0;
            state    <= S_WAIT;
          end else if (win_req_i) begin
            give_ack <= 1'b1;
            state    <= S_WAIT;
            case (op_i)
              OP_NOP: begin
                cmd_q <= CMD_NOP;
                cke_o <= 1'b1;
                cnt   <= cke_o ? CW'(1) : at_least_one(CW'(txsr_i));
              end
              OP_PALL: begin
                cmd_q  <= CMD_PRE;
                addr_o <= ADDR_A10;
                cnt    <= at_least_one(CW'(trp_i));
              end
              OP_AREF: begin
                cmd_q <= CMD_REF;
                cnt   <= at_least_one(CW'(trc_i));
              end
              OP_LMR: begin
                cmd_q  <= CMD_LMR;
                addr_o <= MODE_WORD_BASE | (ADDR_W'(cas_i) << 4);
                cnt    <= CW'(2);
              end
              default: begin
                cmd_q <= CMD_ACT;
                cnt   <= at_least_one(act_len);
                state <= S_ACT;
              end
            endcase
          end
        end
        S_ACT: begin
          if (cnt <= CW'(1)) begin
            cmd_q  <= CMD_PRE;
            addr_o <= ADDR_A10;
            cnt    <= at_least_one(CW'(trp_i));
            state  <= S_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt <= CW'(1)) begin
            win_ack_o <= give_ack;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int RT_W       = 16,
  parameter int PEND_W     = 2,
  parameter int BURST_CODE = 0,
  parameter int SIZE_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              win_req,
  output logic              win_ack,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [SIZE_W-1:0] size_bytes
);

  op_e             op;
  logic [RT_W-1:0] period;
  logic            period_load;
  logic [1:0]      cas;
  logic [TW-1:0]   trp, trc, tras, trcd, twr, txsr;
  logic            ref_pend;
  logic            ref_take;

  sdcmd_regs #(.RT_W(RT_W), .SIZE_W(SIZE_W)) regs_i (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .rdata_o(reg_rdata), .op_o(op), .period_o(period), .period_load_o(period_load),
    .cas_o(cas), .trp_o(trp), .trc_o(trc), .tras_o(tras), .trcd_o(trcd),
    .twr_o(twr), .txsr_o(txsr), .size_o(size_bytes)
  );

  sdcmd_rtimer #(.RT_W(RT_W), .PEND_W(PEND_W)) rtimer_i (
    .clk(clk), .rst(rst), .run_i(is_normal(op)), .period_i(period),
    .load_i(period_load), .load_val_i(reg_wdata[RT_W-1:0]),
    .take_i(ref_take), .pend_o(ref_pend)
  );

  sdcmd_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .BURST_CODE(BURST_CODE)) seq_i (
    .clk(clk), .rst(rst), .op_i(op), .win_req_i(win_req), .ref_pend_i(ref_pend),
    .cas_i(cas), .trp_i(trp), .trc_i(trc), .tras_i(tras), .trcd_i(trcd),
    .twr_i(twr), .txsr_i(txsr), .ref_take_o(ref_take), .win_ack_o(win_ack),
    .cke_o(sd_cke), .cs_n_o(sd_cs_n), .ras_n_o(sd_ras_n), .cas_n_o(sd_cas_n),
    .we_n_o(sd_we_n), .ba_o(sd_ba), .addr_o(sd_addr)
  );

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker #(
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cke,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic            a10,
  input logic            ack
);

  logic [3:0] enc;
  assign enc = {cs_n, ras_n, cas_n, we_n};

  // R4: clock enable never drops once raised
  p_cke_sticky_r4: assert property (@(posedge clk) disable iff (rst) cke |=> cke);

  // R4: a NOP command appears together with clock enable
  p_nop_cke_r4: assert property (@(posedge clk) disable iff (rst) (enc == 4'b0111) |-> cke);

  // R5: precharge-all carries address bit 10 high
  p_pall_a10_r5: assert property (@(posedge clk) disable iff (rst) (enc == 4'b0010) |-> a10);

  // R7: load-mode command uses bank 0
  p_lmr_bank_r7: assert property (@(posedge clk) disable iff (rst) (enc == 4'b0000) |-> (ba == '0));

  // R12: a command is followed by deselect
  p_one_cycle_r12: assert property (@(posedge clk) disable iff (rst) !cs_n |=> cs_n);

  // R12: acknowledge is a single-cycle pulse
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);

endmodule

bind sdram_cmd_issuer sdcmd_checker #(.BA_W(BA_W)) chk_i (
  .clk(clk), .rst(rst), .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
  .cas_n(sd_cas_n), .we_n(sd_we_n), .ba(sd_ba), .a10(sd_addr[10]), .ack(win_ack)
);

// File: tb/sdram_cmd_issuer_tb.sv
module sdram_cmd_issuer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        win_req = 1'b0;
  logic        win_ack;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic [31:0] size_bytes;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_issuer dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .win_req(win_req), .win_ack(win_ack), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .size_bytes(size_bytes)
  );

  // cas=2, wide16, bank code 1, row code 2, col code 1; twr 2 trc 3 trp 3 trcd 2 tras 11 txsr 7
  localparam logic [31:0] CFG = 32'h7B2332B9;

  // {op[26:24], first cmd[23:20], ack latency[19:15], commands[14:13], first addr[12:0]}
  localparam logic [26:0] VEC [5] = '{
    {3'd1, 4'b0111, 5'd7,  2'd1, 13'h000},
    {3'd2, 4'b0010, 5'd3,  2'd1, 13'h400},
    {3'd3, 4'b0001, 5'd3,  2'd1, 13'h000},
    {3'd4, 4'b0000, 5'd2,  2'd1, 13'h020},
    {3'd0, 4'b0011, 5'd14, 2'd2, 13'h000}
  };

  // refresh monitor, sampled off the clock edges
  int cyc = 0, ref_cnt = 0, last_ref = 0, prev_ref = 0;
  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    if (!rst && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001) begin
      ref_cnt  = ref_cnt + 1;
      prev_ref = last_ref;
      last_ref = cyc;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // called at a falling edge; raises the request and waits for the acknowledge
  task automatic access(output logic [3:0] fcmd, output logic [12:0] faddr,
                        output logic [1:0] fba, output int ncmd, output int lat);
    ncmd = 0; lat = -1; fcmd = 4'hF; faddr = '0; fba = '0;
    win_req = 1'b1;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (!sd_cs_n) begin
        if (ncmd == 0) begin
          fcmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
          faddr = sd_addr; fba = sd_ba;
        end
        ncmd++;
      end
      if (win_ack) begin
        lat = c;
        break;
      end
    end
    win_req = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  fc;
    logic [12:0] fa;
    logic [1:0]  fb;
    int n, lat, r0, hits;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'hF);
    chk("R1 cke", 32'(sd_cke), 32'd0);
    chk("R1 ack", 32'(win_ack), 32'd0);
    chk("R1 size", size_bytes, 32'h400000);
    rd_reg(2'd1, d); chk("R1 op reg", d, 32'd0);

    // R9: interval 0 means no refresh in normal operation
    r0 = ref_cnt;
    repeat (60) @(negedge clk);
    chk("R9 disabled", 32'(ref_cnt - r0), 32'd0);

    // R2 readback
    wr_reg(2'd0, CFG);      rd_reg(2'd0, d); chk("R2 cfg", d, CFG);
    wr_reg(2'd1, 32'hFD);   rd_reg(2'd1, d); chk("R2 op", d, 32'd5);
    wr_reg(2'd2, 32'hBEEF); rd_reg(2'd2, d); chk("R2 interval", d, 32'hBEEF);
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd1, 32'd0);

    // R3 capacity
    wr_reg(2'd0, 32'h0000001F); @(negedge clk);
    chk("R3 size 32-bit max", size_bytes, 32'h20000000);
    wr_reg(2'd0, CFG); @(negedge clk);
    chk("R3 size 16-bit", size_bytes, 32'h2000000);

    // table walk through every operation
    for (int i = 0; i < 5; i++) begin
      wr_reg(2'd1, 32'(VEC[i][26:24]));
      access(fc, fa, fb, n, lat);
      chk({tag_of(VEC[i][26:24]), " command"}, 32'(fc), 32'(VEC[i][23:20]));
      chk({tag_of(VEC[i][26:24]), " latency"}, 32'(lat), 32'(VEC[i][19:15]));
      chk({tag_of(VEC[i][26:24]), " address"}, 32'(fa), 32'(VEC[i][12:0]));
      chk({tag_of(VEC[i][26:24]), " bank"}, 32'(fb), 32'd0);
      chk("R12 command count", 32'(n), 32'(VEC[i][14:13]));
    end
    chk("R4 cke stays high", 32'(sd_cke), 32'd1);

    // R4: NOP with clock already on acknowledges after one cycle
    wr_reg(2'd1, 32'd1);
    access(fc, fa, fb, n, lat);
    chk("R4 second nop latency", 32'(lat), 32'd1);

    // R6: eight refresh accesses give eight refreshes
    wr_reg(2'd1, 32'd3);
    r0 = ref_cnt; hits = 0;
    for (int k = 0; k < 8; k++) begin
      access(fc, fa, fb, n, lat);
      if (fc == 4'b0001 && n == 1) hits++;
    end
    chk("R6 eight accesses", 32'(hits), 32'd8);
    chk("R6 eight refreshes", 32'(ref_cnt - r0), 32'd8);

    // R9 periodic refresh
    wr_reg(2'd1, 32'd0);
    wr_reg(2'd2, 32'd20);
    r0 = ref_cnt;
    repeat (70) @(negedge clk);
    chk("R9 refresh count", 32'(ref_cnt - r0), 32'd3);
    chk("R9 interval", 32'(last_ref - prev_ref), 32'd20);

    // R9 frozen outside normal operation
    wr_reg(2'd1, 32'd1);
    r0 = ref_cnt;
    repeat (60) @(negedge clk);
    chk("R9 frozen", 32'(ref_cnt - r0), 32'd0);
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd1, 32'd0);

    // R10: pending refresh goes ahead of a queued access
    wr_reg(2'd2, 32'd6);
    win_req = 1'b1;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (win_ack) break;
    end
    @(negedge clk);
    chk("R10 refresh first", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h1);
    for (int c = 0; c < 300; c++) begin
      if (win_ack) break;
      @(negedge clk);
    end
    win_req = 1'b0;
    wr_reg(2'd2, 32'd0);

    // R11: two expirations during one access yield two refreshes
    wr_reg(2'd2, 32'd7);
    access(fc, fa, fb, n, lat);
    r0 = ref_cnt;
    repeat (6) @(negedge clk);
    chk("R11 backlog", 32'(ref_cnt - r0), 32'd2);
    wr_reg(2'd2, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule